// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Latch

This block turns an asynchronous interrupt request pin on a parallel digital I/O card into a clean, sticky interrupt flag for the host. The request pin and an active-low enable pin are each brought into the clock domain through a synchronizer chain. The block then looks for one selectable edge of the request, either rising or falling. An edge that arrives while the enable pin is high is dropped.

The edge that sets the flag can also capture a snapshot of the card's I/O ports. Each port has its own direction bit. When latching is switched on, every port marked as an input copies its pin values into a holding register on the trigger. Ports marked as outputs keep the value they hold.

Software uses a small register interface. It picks the edge, turns latching on or off, sets the port directions, enables the host interrupt line, clears the flag and reads back the captured port data. A write that only changes the edge selection never triggers the flag by itself. The host line is the flag gated by an enable bit, and turning that bit off leaves the flag untouched.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the control register reads 0 (rising edge, latching off, host line disabled, all ports output), the flag reads 0, every holding register reads 0 and `host_irq` is low.
- R2: With control bit 0 = 0, a rising edge on `req_pin` sets the flag (status bit 0), and a falling edge does not.
- R3: With control bit 0 = 1, a falling edge on `req_pin` sets the flag, and a rising edge does not.
- R4: While `en_n_pin` is high, no edge on `req_pin` sets the flag or captures port data.
- R5: The flag stays set until a write to address 1 with data bit 0 = 1. A write there with bit 0 = 0 leaves it set.
- R6: When a trigger edge and a clearing write to address 1 fall in the same cycle, the flag ends up set.
- R7: With control bit 1 = 1, the trigger copies each port whose direction bit (control bit 3+p, 1 = input) is set into holding register p, read at address 2+p.
- R8: Holding registers of ports with direction bit 0 keep their value on a trigger, and no holding register changes on a trigger while control bit 1 = 0.
- R9: A control write that only changes bit 0 while `req_pin` stays steady does not set the flag.
- R10: `host_irq` is high exactly when the flag is set and control bit 2 = 1. Clearing bit 2 does not clear the flag.
- R11: Address 0 reads back the control fields in the bit positions listed above, address 1 reads the flag in bit 0, and unused bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pin | input | 1 | Asynchronous external interrupt request |
| en_n_pin | input | 1 | Asynchronous external enable, active low |
| port_in | input | NUM_PORTS*PORT_W | Current values of the I/O ports, port p at bits p*PORT_W |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | PORT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | PORT_W | Register read data, combinational from rd_addr |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
A level change driven on `req_pin` reaches the flag, the holding registers and `host_irq` on the third rising clock edge: two synchronizer stages and then the flag register. The bench drives its inputs at falling edges and checks three falling edges after the pin change. A register write takes effect on the next rising edge. A read is combinational and is sampled one time step after its address is set. The same-cycle collision of R6 is built by timing the clear write to the second falling edge after the pin change, so that it lands on the edge where the flag is set.

// File: rtl/eil_pkg.sv
`timescale 1ns/1ps
package eil_pkg;
   // control register field positions (software-visible layout)
   localparam int CTRL_POL_BIT    = 0;
   localparam int CTRL_LATCH_BIT  = 1;
   localparam int CTRL_HOSTEN_BIT = 2;
   localparam int CTRL_DIR_LSB    = 3;
   // register addresses
   localparam int ADDR_CTRL  = 0;
   localparam int ADDR_STAT  = 1;
   localparam int ADDR_HOLD0 = 2;
   localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/eil_sync.sv
`timescale 1ns/1ps
module eil_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eil_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("eil_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eil_edge_det.sv
`timescale 1ns/1ps
module eil_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,      // synchronized request
   input  logic en_n_s,     // synchronized enable, active low
   input  logic edge_sel,   // 0 rising, 1 falling
   input  logic pol_wr,     // polarity register written this cycle
   input  logic pol_new,    // value being written
   output logic trig
);
   logic lvl;
   logic prev_q;

   // normalise so that the selected edge is always a 0->1 step of lvl
   assign lvl  = req_s ^ edge_sel;
   assign trig = lvl & ~prev_q & ~en_n_s;

   always_ff @(posedge clk) begin
      if (!rst_n)      prev_q <= 1'b0;
      else if (pol_wr) prev_q <= req_s ^ pol_new;  // reload: no step from polarity change
      else             prev_q <= lvl;
   end

   // R4: a trigger only while the enable is asserted
   assert_trig_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> !en_n_s);
   // R2/R3: the request level after a trigger matches the selected edge
   assert_trig_level_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (req_s == ~edge_sel));
   // R9: with a steady request, a polarity write produces no trigger next cycle
   assert_no_pol_glitch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_wr && !trig) ##1 $stable(req_s) |-> !trig);
endmodule

// File: rtl/eil_port_latch.sv
`timescale 1ns/1ps
module eil_port_latch #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap,
   input  logic [NUM_PORTS-1:0]          dir_in,
   input  logic [NUM_PORTS*PORT_W-1:0]   data,
   output logic [NUM_PORTS*PORT_W-1:0]   hold
);
   genvar g;
   generate
      for (g = 0; g < NUM_PORTS; g++) begin : g_port
         always_ff @(posedge clk) begin
            if (!rst_n)                hold[g*PORT_W +: PORT_W] <= '0;
            else if (cap && dir_in[g]) hold[g*PORT_W +: PORT_W] <= data[g*PORT_W +: PORT_W];
         end

         // R7: an input port captures the pin values on a capture event
         assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cap && dir_in[g]) |=> hold[g*PORT_W +: PORT_W] == $past(data[g*PORT_W +: PORT_W]));
         // R8: no capture for this port means its holding value is kept
         assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cap && dir_in[g]) |=> $stable(hold[g*PORT_W +: PORT_W]));
      end
   endgenerate
endmodule

// File: rtl/ext_irq_latch.sv
`timescale 1ns/1ps
module ext_irq_latch
   import eil_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int NUM_PORTS   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(NUM_PORTS + ADDR_HOLD0)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_pin,
   input  logic                        en_n_pin,
   input  logic [NUM_PORTS*PORT_W-1:0] port_in,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [PORT_W-1:0]           wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [PORT_W-1:0]           rd_data,
   output logic                        host_irq
);
   localparam int CTRL_USED = CTRL_DIR_LSB + NUM_PORTS;
   localparam int NUM_REGS  = ADDR_HOLD0 + NUM_PORTS;

   generate
      if (CTRL_USED > PORT_W) begin : g_bad_ctrl
         $error("ext_irq_latch: control fields do not fit in PORT_W");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("ext_irq_latch: ADDR_W too small for register map");
      end
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("ext_irq_latch: NUM_PORTS must be at least 1");
      end
   endgenerate

   // ---------------- control / status registers ----------------
   logic                 pol_q, latch_q, hosten_q, flag_q;
   logic [NUM_PORTS-1:0] dir_q;
   logic                 wr_ctrl, wr_clr;
   logic                 req_s, en_n_s, trig;
   logic [NUM_PORTS*PORT_W-1:0] hold;
   logic                 unused_wr;

   assign wr_ctrl   = wr_en && (int'(wr_addr) == ADDR_CTRL);
   assign wr_clr    = wr_en && (int'(wr_addr) == ADDR_STAT) && wr_data[STAT_FLAG_BIT];
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q    <= 1'b0;
         latch_q  <= 1'b0;
         hosten_q <= 1'b0;
         dir_q    <= '0;
      end else if (wr_ctrl) begin
         pol_q    <= wr_data[CTRL_POL_BIT];
         latch_q  <= wr_data[CTRL_LATCH_BIT];
         hosten_q <= wr_data[CTRL_HOSTEN_BIT];
         dir_q    <= wr_data[CTRL_DIR_LSB +: NUM_PORTS];
      end
   end

   // ---------------- input conditioning ----------------
   eil_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({en_n_pin, req_pin}),
      .q     ({en_n_s, req_s})
   );

   eil_edge_det edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_s),
      .en_n_s   (en_n_s),
      .edge_sel (pol_q),
      .pol_wr   (wr_ctrl),
      .pol_new  (wr_data[CTRL_POL_BIT]),
      .trig     (trig)
   );

   // ---------------- sticky flag: set has priority over clear ----------------
   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (trig)   flag_q <= 1'b1;
      else if (wr_clr) flag_q <= 1'b0;
   end

   assign host_irq = flag_q & hosten_q;

   // ---------------- port capture ----------------
   eil_port_latch #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (trig & latch_q),
      .dir_in (dir_q),
      .data   (port_in),
      .hold   (hold)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) == ADDR_CTRL) begin
         rd_data[CTRL_POL_BIT]                = pol_q;
         rd_data[CTRL_LATCH_BIT]              = latch_q;
         rd_data[CTRL_HOSTEN_BIT]             = hosten_q;
         rd_data[CTRL_DIR_LSB +: NUM_PORTS]   = dir_q;
      end else if (int'(rd_addr) == ADDR_STAT) begin
         rd_data[STAT_FLAG_BIT] = flag_q;
      end
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (int'(rd_addr) == ADDR_HOLD0 + i) rd_data = hold[i*PORT_W +: PORT_W];
      end
   end

   // ---------------- assertions ----------------
   // R2/R3/R6: a trigger always leaves the flag set, whatever else is written
   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> flag_q);
   // R5: a clearing write with no trigger drops the flag
   assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !trig) |=> !flag_q);
   // R5: without a clearing write the flag never falls
   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_clr) |=> flag_q);
   // R10: the host line cannot rise without the flag being set
   assert_host_follows_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !trig) |=> !host_irq);
endmodule

// File: tb/ext_irq_latch_tb_top.sv
`timescale 1ns/1ps
module ext_irq_latch_tb_top;
   localparam int PW = 8;
   localparam int NP = 3;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_pin = 1'b0;
   logic          en_n_pin = 1'b0;
   logic [NP*PW-1:0] port_in = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [PW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [PW-1:0] rd_data;
   logic          host_irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic [PW-1:0] exp_hold [NP];

   always #5 clk = ~clk;

   ext_irq_latch #(.PORT_W(PW), .NUM_PORTS(NP), .SYNC_STAGES(2), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .en_n_pin(en_n_pin),
      .port_in(port_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .host_irq(host_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = PW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int addr, output int val);
      rd_addr = AW'(addr);
      #1;
      val = int'(rd_data);
   endtask

   task automatic set_req(input logic v);
      @(negedge clk);
      req_pin = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic set_en_n(input logic v);
      @(negedge clk);
      en_n_pin = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v;
      for (int p = 0; p < NP; p++) exp_hold[p] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v); check("R1 ctrl", v, 0);
      rd(1, v); check("R1 flag", v, 0);
      for (int p = 0; p < NP; p++) begin rd(2 + p, v); check("R1 hold", v, 0); end
      check("R1 host_irq", int'(host_irq), 0);
      rd(5, v); check("R11 unused addr", v, 0);

      // sweep: polarity x enable x latch x direction
      for (int k = 0; k < 64; k++) begin
         int sel, en, lat, dir, ctrl;
         logic newlvl;
         logic [PW-1:0] pat [NP];
         bit fire;
         sel = (k >> 5) & 1; en = (k >> 4) & 1; lat = (k >> 3) & 1; dir = k & 7;
         ctrl = sel | (lat << 1) | (1 << 2) | (dir << 3);
         wr(0, ctrl);
         rd(0, v); check("R11 ctrl readback", v, ctrl);
         set_en_n(logic'(en));
         wr(1, 1);
         for (int p = 0; p < NP; p++) pat[p] = PW'((k * 37 + p * 91 + 5) & 255);
         port_in = {pat[2], pat[1], pat[0]};
         newlvl = ~req_pin;
         set_req(newlvl);
         fire = (en == 0) && (int'(newlvl) != sel);
         if (fire && lat == 1)
            for (int p = 0; p < NP; p++) if (((dir >> p) & 1) == 1) exp_hold[p] = pat[p];
         rd(1, v);
         if (en == 1)          check("R4 flag gated", v, 0);
         else if (sel == 0)    check("R2 rising edge flag", v, int'(fire));
         else                  check("R3 falling edge flag", v, int'(fire));
         check("R10 host_irq follows flag", int'(host_irq), int'(fire));
         for (int p = 0; p < NP; p++) begin
            rd(2 + p, v);
            if (fire && lat == 1 && ((dir >> p) & 1) == 1) check("R7 capture", v, int'(exp_hold[p]));
            else check("R8 hold kept", v, int'(exp_hold[p]));
         end
      end

      // directed: rising polarity, enabled, host line on, no latching
      wr(0, 32'h04);
      set_en_n(1'b0);
      set_req(1'b0);
      wr(1, 1);
      rd(1, v); check("R5 clear works", v, 0);

      // R9: polarity toggles with steady high request
      set_req(1'b1);
      wr(1, 1);
      wr(0, 32'h05);
      wr(0, 32'h04);
      repeat (3) @(negedge clk);
      rd(1, v); check("R9 no flag from polarity writes", v, 0);

      // R5: set then write 0 -> stays
      set_req(1'b0);
      set_req(1'b1);
      rd(1, v); check("R2 flag set", v, 1);
      wr(1, 0);
      rd(1, v); check("R5 write zero keeps flag", v, 1);

      // R10: mask keeps flag
      wr(0, 32'h00);
      check("R10 masked host_irq", int'(host_irq), 0);
      rd(1, v); check("R10 flag retained when masked", v, 1);
      wr(0, 32'h04);
      check("R10 unmasked host_irq", int'(host_irq), 1);

      // R6: clear coincides with trigger edge
      set_req(1'b0);
      wr(1, 1);
      rd(1, v); check("R5 cleared before collision", v, 0);
      @(negedge clk);
      req_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(1); wr_data = PW'(1);
      @(negedge clk);
      wr_en = 1'b0;
      rd(1, v); check("R6 set wins over clear", v, 1);
      wr(1, 1);
      rd(1, v); check("R5 clear after collision", v, 0);

      finish_run();
   end
endmodule